// File: doc/BRIEF.md
# Flash Page Map Table Rebuilder

After a reset, an emulated-EEPROM flash sector has no valid logical-to-physical page map. This block rebuilds it. The sector has 33 physical pages behind 32 logical pages. Each physical page carries a small control record. The record holds the logical page it backs, a second copy of that link with every bit inverted, an ECC-ok flag and an erased flag. The ECC and threshold logic sit outside the block and deliver those flags.

A rebuild begins with a start pulse and a 5-bit random starting page. The block reads one record per accepted read, moving upward through the physical pages. After the last page it wraps to page 0, and it stops when it returns to the starting page. A good record writes the current physical page number into the table entry that the record's link selects. An erased page is passed over. The scan stops early in two cases: a corrupt record, or a link that selects an entry which is already filled. In either case every page later in scan order stays unmapped, and the block reports why it stopped and at which page.

The table is read through a combinational lookup port. Software or a flash controller uses that port to translate logical page addresses once `done_o` is high.

Top module: `mrb_map_rebuild`

## Requirements
- R1: Directly after reset all 32 table entries miss on lookup, and `done_o`, `abort_o` and `abort_code_o` are all 0.
- R2: A start pulse accepted while no scan is running makes the first read address equal the start index. Each read that `rd_valid_i` completes moves the read address up by one.
- R3: After physical page 32 the read address wraps to 0. A scan without errors ends when the next page would be the start page, so each page is read exactly once. `done_o` is then 1 and `abort_o` is 0.
- R4: A record with its erased flag set is skipped whatever its other fields hold. No table entry changes and the scan goes on.
- R5: A good record sets the entry selected by its 5-bit link to valid, with a 6-bit physical index equal to the page being read.
- R6: A non-erased record counts as faulty when its ECC-ok flag is 0 or when its inverted copy is not the bitwise complement of its link. A faulty record stops the scan at once with `abort_code_o` = 2'b01, `abort_o` and `done_o` = 1, and `abort_page_o` set to that page.
- R7: A good record whose link selects an entry that is already valid stops the scan with `abort_code_o` = 2'b10, and `abort_page_o` set to that page. The existing entry is kept.
- R8: After a stop, entries written before the stopping page keep their values. Pages after it in scan order leave no entry.
- R9: Each accepted start clears the whole table, `done_o` and the abort report before the new scan begins.
- R10: While `rd_req_o` is 1 and `rd_valid_i` is 0, the read address holds and the request stays up. The result does not depend on the number of wait cycles.
- R11: `lkup_hit_o` and `lkup_phys_o` follow `lkup_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a rebuild (taken when no scan is running) |
| start_idx_i | input | 5 | Random starting physical page |
| rd_req_o | output | 1 | Record read request |
| rd_addr_o | output | 6 | Physical page being read |
| rd_valid_i | input | 1 | Record fields valid this cycle |
| rd_link_i | input | 5 | Logical link, true form |
| rd_link_n_i | input | 5 | Logical link, inverted copy |
| rd_ecc_ok_i | input | 1 | Record ECC check passed |
| rd_erased_i | input | 1 | Page reads as erased or weakly erased |
| lkup_addr_i | input | 5 | Logical page to translate |
| lkup_hit_o | output | 1 | Entry is valid |
| lkup_phys_o | output | 6 | Physical page for the entry |
| done_o | output | 1 | Scan finished or stopped |
| abort_o | output | 1 | Scan stopped early |
| abort_code_o | output | 2 | 00 none, 01 faulty record, 10 double mapping |
| abort_page_o | output | 6 | Physical page where the scan stopped |

## Verification
The bench uses the default sizes of 32 logical and 33 physical pages. These are small enough to sweep every one of the 32 start indices over a complete, permuted layout. Each sweep places the free page at a different spot, including page 32 and pages across the wrap. Directed layouts put a faulty or duplicate record at the start page, just after the wrap, and in the middle of the sector. Each such run checks the stop report and all 32 lookups against a map that the bench builds from the requirements. Some runs insert read wait states to show the outcome does not change.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  typedef enum logic [1:0] {
    ABT_NONE  = 2'b00,
    ABT_FAULT = 2'b01,
    ABT_DUP   = 2'b10
  } abort_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_DONE
  } scan_st_e;
endpackage

// File: rtl/mrb_rec_check.sv
module mrb_rec_check #(
  parameter int LOG_W = 5
) (
  input  logic [LOG_W-1:0] link_i,
  input  logic [LOG_W-1:0] link_n_i,
  input  logic             ecc_ok_i,
  input  logic             erased_i,
  output logic             empty_o,
  output logic             faulty_o
);
  // erased takes priority: its record contents are meaningless
  assign empty_o  = erased_i;
  assign faulty_o = !erased_i && (!ecc_ok_i || ((link_i ^ link_n_i) != '1));
endmodule

// File: rtl/mrb_map_table.sv
module mrb_map_table #(
  parameter int NUM_LOG = 32,
  parameter int PHYS_W  = 6,
  localparam int LOG_W  = $clog2(NUM_LOG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [LOG_W-1:0]  wr_idx_i,
  input  logic [PHYS_W-1:0] wr_phys_i,
  input  logic [LOG_W-1:0]  chk_idx_i,
  output logic              chk_valid_o,
  input  logic [LOG_W-1:0]  lk_idx_i,
  output logic              lk_valid_o,
  output logic [PHYS_W-1:0] lk_phys_o
);
  logic [NUM_LOG-1:0] vld_q;
  logic [PHYS_W-1:0]  phys_q [NUM_LOG];

  for (genvar e = 0; e < NUM_LOG; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e]  <= 1'b0;
        phys_q[e] <= '0;
      end else if (clr_i) begin
        vld_q[e]  <= 1'b0;
        phys_q[e] <= '0;
      end else if (wr_en_i && wr_idx_i == LOG_W'(e)) begin
        vld_q[e]  <= 1'b1;
        phys_q[e] <= wr_phys_i;
      end
    end
  end

  assign chk_valid_o = vld_q[chk_idx_i];
  assign lk_valid_o  = vld_q[lk_idx_i];
  assign lk_phys_o   = vld_q[lk_idx_i] ? phys_q[lk_idx_i] : '0;
endmodule

// File: rtl/mrb_scan_seq.sv
module mrb_scan_seq
  import mrb_pkg::*;
#(
  parameter int NUM_PHYS = 33,
  parameter int PHYS_W   = 6,
  parameter int LOG_W    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LOG_W-1:0]  start_idx_i,
  input  logic              rd_valid_i,
  input  logic              empty_i,
  input  logic              faulty_i,
  input  logic              dup_i,
  output logic              rd_req_o,
  output logic [PHYS_W-1:0] cur_o,
  output logic              wr_en_o,
  output logic              clr_o,
  output logic              done_o,
  output abort_e            code_o,
  output logic [PHYS_W-1:0] abort_page_o
);
  localparam logic [PHYS_W-1:0] LastPage = PHYS_W'(NUM_PHYS - 1);

  scan_st_e          st_q;
  logic [PHYS_W-1:0] cur_q, first_q, cur_nxt, page_q;
  abort_e            code_q;
  logic              take, fault_hit, dup_hit;

  assign cur_nxt   = (cur_q == LastPage) ? '0 : cur_q + 1'b1;
  assign take      = (st_q == ST_READ) && rd_valid_i;
  assign fault_hit = take && faulty_i;
  assign dup_hit   = take && !empty_i && !faulty_i && dup_i;
  assign wr_en_o   = take && !empty_i && !faulty_i && !dup_i;
  assign clr_o     = start_i && (st_q != ST_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      first_q <= '0;
      code_q  <= ABT_NONE;
      page_q  <= '0;
    end else if (clr_o) begin
      st_q    <= ST_READ;
      cur_q   <= PHYS_W'(start_idx_i);
      first_q <= PHYS_W'(start_idx_i);
      code_q  <= ABT_NONE;
      page_q  <= '0;
    end else if (take) begin
      if (fault_hit || dup_hit) begin
        st_q   <= ST_DONE;
        code_q <= fault_hit ? ABT_FAULT : ABT_DUP;
        page_q <= cur_q;
      end else if (cur_nxt == first_q) begin
        st_q <= ST_DONE;
      end else begin
        cur_q <= cur_nxt;
      end
    end
  end

  assign rd_req_o     = (st_q == ST_READ);
  assign cur_o        = cur_q;
  assign done_o       = (st_q == ST_DONE);
  assign code_o       = code_q;
  assign abort_page_o = page_q;
endmodule

// File: rtl/mrb_map_rebuild.sv
module mrb_map_rebuild
  import mrb_pkg::*;
#(
  parameter int NUM_LOG  = 32,
  parameter int NUM_PHYS = 33,
  localparam int LOG_W   = $clog2(NUM_LOG),
  localparam int PHYS_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LOG_W-1:0]  start_idx_i,
  output logic              rd_req_o,
  output logic [PHYS_W-1:0] rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [LOG_W-1:0]  rd_link_i,
  input  logic [LOG_W-1:0]  rd_link_n_i,
  input  logic              rd_ecc_ok_i,
  input  logic              rd_erased_i,
  input  logic [LOG_W-1:0]  lkup_addr_i,
  output logic              lkup_hit_o,
  output logic [PHYS_W-1:0] lkup_phys_o,
  output logic              done_o,
  output logic              abort_o,
  output logic [1:0]        abort_code_o,
  output logic [PHYS_W-1:0] abort_page_o
);
  logic   empty, faulty, dup, wr_en, clr;
  abort_e code;

  mrb_rec_check #(.LOG_W(LOG_W)) rec_i (
    .link_i   (rd_link_i),
    .link_n_i (rd_link_n_i),
    .ecc_ok_i (rd_ecc_ok_i),
    .erased_i (rd_erased_i),
    .empty_o  (empty),
    .faulty_o (faulty)
  );

  mrb_map_table #(.NUM_LOG(NUM_LOG), .PHYS_W(PHYS_W)) tbl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .wr_en_i     (wr_en),
    .wr_idx_i    (rd_link_i),
    .wr_phys_i   (rd_addr_o),
    .chk_idx_i   (rd_link_i),
    .chk_valid_o (dup),
    .lk_idx_i    (lkup_addr_i),
    .lk_valid_o  (lkup_hit_o),
    .lk_phys_o   (lkup_phys_o)
  );

  mrb_scan_seq #(.NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .LOG_W(LOG_W)) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_idx_i  (start_idx_i),
    .rd_valid_i   (rd_valid_i),
    .empty_i      (empty),
    .faulty_i     (faulty),
    .dup_i        (dup),
    .rd_req_o     (rd_req_o),
    .cur_o        (rd_addr_o),
    .wr_en_o      (wr_en),
    .clr_o        (clr),
    .done_o       (done_o),
    .code_o       (code),
    .abort_page_o (abort_page_o)
  );

  assign abort_code_o = code;
  assign abort_o      = (code != ABT_NONE);
endmodule

// File: rtl/mrb_map_rebuild_chk.sv
module mrb_map_rebuild_chk #(
  parameter int LOG_W    = 5,
  parameter int PHYS_W   = 6,
  parameter int NUM_PHYS = 33
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [LOG_W-1:0]  start_idx_i,
  input logic              rd_req_o,
  input logic [PHYS_W-1:0] rd_addr_o,
  input logic              rd_valid_i,
  input logic              rd_ecc_ok_i,
  input logic              rd_erased_i,
  input logic              done_o,
  input logic              abort_o,
  input logic [1:0]        abort_code_o
);
  // R2
  start_first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !rd_req_o) |=> (rd_req_o && rd_addr_o == PHYS_W'($past(start_idx_i))));

  // R10
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

  // R3
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o < PHYS_W'(NUM_PHYS)));

  // R3
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !rd_req_o);

  // R6
  ecc_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && rd_valid_i && !rd_erased_i && !rd_ecc_ok_i) |=>
      (done_o && abort_o && abort_code_o == 2'b01));

  // R7
  abort_implies_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (done_o && abort_code_o != 2'b00 && abort_code_o != 2'b11));
endmodule

bind mrb_map_rebuild mrb_map_rebuild_chk #(
  .LOG_W(LOG_W), .PHYS_W(PHYS_W), .NUM_PHYS(NUM_PHYS)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_idx_i  (start_idx_i),
  .rd_req_o     (rd_req_o),
  .rd_addr_o    (rd_addr_o),
  .rd_valid_i   (rd_valid_i),
  .rd_ecc_ok_i  (rd_ecc_ok_i),
  .rd_erased_i  (rd_erased_i),
  .done_o       (done_o),
  .abort_o      (abort_o),
  .abort_code_o (abort_code_o)
);

// File: tb/mrb_map_rebuild_tb_top.sv
module mrb_map_rebuild_tb_top;
  localparam int NL = 32;
  localparam int NP = 33;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] start_idx_i = '0;
  logic       rd_req_o;
  logic [5:0] rd_addr_o;
  logic       rd_valid_i = 1'b0;
  logic [4:0] rd_link_i = '0, rd_link_n_i = '0;
  logic       rd_ecc_ok_i = 1'b0, rd_erased_i = 1'b0;
  logic [4:0] lkup_addr_i = '0;
  logic       lkup_hit_o;
  logic [5:0] lkup_phys_o;
  logic       done_o, abort_o;
  logic [1:0] abort_code_o;
  logic [5:0] abort_page_o;

  always #5 clk_i = ~clk_i;

  mrb_map_rebuild dut_i (.*);

  int checks = 0, errors = 0;
  int m_link [NP];
  bit m_erased [NP], m_badcmp [NP], m_badecc [NP];
  int stall_n = 0, stall_cnt = 0, exp_addr = 0, reads = 0, order_err = 0;
  bit e_vld [NL];
  int e_phys [NL];
  int e_code, e_page, e_reads;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // read responder
  initial forever begin
    @(negedge clk_i);
    stall_cnt++;
    if (rd_req_o && (stall_n == 0 || (stall_cnt % stall_n) != 0)) begin
      int a;
      a = int'(rd_addr_o);
      rd_valid_i  = 1'b1;
      rd_link_i   = 5'(m_link[a]);
      rd_link_n_i = m_badcmp[a] ? 5'(m_link[a]) : ~5'(m_link[a]);
      rd_ecc_ok_i = !m_badecc[a];
      rd_erased_i = m_erased[a];
      if (a != exp_addr) order_err++;
      exp_addr = (exp_addr == NP - 1) ? 0 : exp_addr + 1;
      reads++;
    end else begin
      rd_valid_i = 1'b0;
    end
  end

  task automatic fill_full(input int spare, input int off);
    int rank = 0;
    for (int p = 0; p < NP; p++) begin
      m_badcmp[p] = 0;
      m_badecc[p] = 0;
      m_erased[p] = (p == spare);
      m_link[p]   = (p == spare) ? 0 : (rank * 7 + off) % NL;
      if (p != spare) rank++;
    end
  endtask

  task automatic model(input int st);
    int p = st;
    e_code = 0; e_page = 0; e_reads = 0;
    for (int i = 0; i < NL; i++) begin e_vld[i] = 0; e_phys[i] = 0; end
    do begin
      e_reads++;
      if (!m_erased[p]) begin
        if (m_badcmp[p] || m_badecc[p]) begin e_code = 1; e_page = p; break; end
        if (e_vld[m_link[p]]) begin e_code = 2; e_page = p; break; end
        e_vld[m_link[p]] = 1;
        e_phys[m_link[p]] = p;
      end
      p = (p == NP - 1) ? 0 : p + 1;
    end while (p != st);
  endtask

  task automatic run(input int st, input int stl, input string tag);
    int w = 0;
    model(st);
    stall_n = stl;
    @(negedge clk_i);
    exp_addr = st; reads = 0; order_err = 0;
    start_i = 1'b1; start_idx_i = 5'(st);
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && w < 2000) begin @(negedge clk_i); w++; end
    chk(done_o == 1'b1, {tag, " R3 done"}, int'(done_o), 1);
    chk(order_err == 0, {tag, " R2 read order"}, order_err, 0);
    chk(reads == e_reads, {tag, " R3 read count"}, reads, e_reads);
    chk(int'(abort_code_o) == e_code, {tag, " R6/R7 code"}, int'(abort_code_o), e_code);
    chk(abort_o == (e_code != 0), {tag, " R6 abort flag"}, int'(abort_o), int'(e_code != 0));
    if (e_code != 0)
      chk(int'(abort_page_o) == e_page, {tag, " R7 abort page"}, int'(abort_page_o), e_page);
    for (int l = 0; l < NL; l++) begin
      lkup_addr_i = 5'(l);
      #1;
      // R5 R8 R11
      chk(lkup_hit_o == e_vld[l], {tag, " R5 hit"}, int'(lkup_hit_o), int'(e_vld[l]));
      if (e_vld[l])
        chk(int'(lkup_phys_o) == e_phys[l], {tag, " R5 phys"}, int'(lkup_phys_o), e_phys[l]);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      m_link[p] = 0; m_erased[p] = 1; m_badcmp[p] = 0; m_badecc[p] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(!done_o, "R1 done", int'(done_o), 0);
    chk(!abort_o && abort_code_o == 2'b00, "R1 abort", int'(abort_code_o), 0);
    for (int l = 0; l < NL; l++) begin
      lkup_addr_i = 5'(l);
      #1;
      chk(!lkup_hit_o, "R1 entry invalid", int'(lkup_hit_o), 0);
    end

    // R2 R3 R5 R10: sweep every start over full layouts
    for (int s = 0; s < NL; s++) begin
      fill_full((s * 5 + 3) % NP, s);
      run(s, (s % 4 == 1) ? 3 : 0, "sweep");
    end
    fill_full(NP - 1, 11);
    run(31, 2, "spare32");

    // R4 all erased, then erased page with garbage record
    for (int p = 0; p < NP; p++) m_erased[p] = 1;
    run(7, 0, "R4 empty");
    fill_full(9, 4);
    m_badcmp[9] = 1; m_badecc[9] = 1;
    run(5, 0, "R4 garbage erased");

    // R6 R8 complement mismatch just after wrap
    fill_full(0, 2);
    m_badcmp[1] = 1;
    run(31, 0, "R6 cmp wrap");
    // R6 R8 ecc fault mid sector with waits
    fill_full(20, 9);
    m_badecc[10] = 1;
    run(4, 2, "R6 ecc");

    // R7 duplicate link
    fill_full(30, 0);
    m_link[20] = m_link[15];
    run(12, 0, "R7 dup");

    // R9 fault on start page: table must be empty after the earlier runs
    fill_full(5, 1);
    m_badecc[0] = 1;
    run(0, 0, "R9 clear");

    // R9 restart after abort rebuilds fully
    fill_full(5, 1);
    run(6, 0, "R9 rerun");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule